// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a byte-oriented asynchronous serial port that a processor drives through seven 32-bit word registers. It has an eight-entry transmit queue and an eight-entry receive queue. One divisor register sets the bit time directly in clock cycles. The transmitter sends frames with eight data bits, no parity, and one or two stop bits. The receiver uses a clock-rate oversampled line, confirms a start bit at mid-bit, and checks the stop bit.

Software learns the port state from flags in bit 31 of the two data registers. It can also use two level-based watermarks. The transmit watermark fires while the transmit queue holds fewer entries than a programmed count. The receive watermark fires while the receive queue holds more entries than its count. Each watermark is gated by an enable bit before it reaches the single interrupt line.

The register interface is a simple strobe: `sel_i` with `wr_i` high writes `wdata_i` to word `addr_i`. `sel_i` with `wr_i` low reads, and `rdata_o` is valid in the same cycle. A read of the receive data word that finds a byte removes that byte at the clock edge.

Top module: `uart_wm`

## Requirements
- R1: Word indices are: 0 transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt enable (bits 1:0), 5 interrupt pending (read-only), 6 divisor. The divisor resets to 15 and reads back as written. One bit lasts divisor+1 clock cycles.
- R2: A read of word 0 returns bit 31 set exactly when the transmit queue holds 8 entries. A write to word 0 queues `wdata_i[7:0]`. A write to word 0 while the queue is full is dropped.
- R3: A read of word 1 returns bit 31 set, and changes nothing, when the receive queue is empty. Otherwise it returns bit 31 clear with the oldest byte in bits 7:0, and that byte leaves the queue.
- R4: A transmitted frame is a low start bit, eight data bits LSB first, and high stop bit(s). A queued byte that is ready at the end of a frame starts on the next cycle, with no idle gap.
- R5: Transmit control bit 0 enables the transmitter. While it is clear, the line stays high and the queued bytes are held.
- R6: Transmit control bit 1 holds the stop-bit count minus one: 0 gives one stop bit, 1 gives two. Start-to-start spacing of back-to-back frames is (9 + stop bits) x (divisor + 1) cycles.
- R7: Interrupt pending bit 0 is set while the transmit queue level is below transmit control bits 19:16. A count of 1 flags a fully empty queue.
- R8: Interrupt pending bit 1 is set while the receive queue level is above receive control bits 19:16.
- R9: `irq_o` is high exactly when some interrupt pending bit is set together with the interrupt enable bit at the same position.
- R10: Receive control bit 0 enables the receiver. While it is clear, incoming frames are not stored.
- R11: A falling edge on `rx_i` begins a start bit only if the line is still low at mid-bit. A shorter low pulse stores nothing.
- R12: A frame whose stop bit samples low is discarded.
- R13: A byte that completes while the receive queue holds 8 entries is discarded, and the older bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| irq_o | output | 1 | Interrupt request |

## Verification
The timing of each result is as follows:
- A register write takes effect at its clock edge, so `irq_o` and any later read already reflect it.
- Read data is combinational, and the bench samples it one nanosecond after driving the address.
- A byte written into an idle, enabled transmitter pulls `tx_o` low one cycle after the write edge.
- A received byte reaches the queue about nine and a half bit times after its start edge plus three synchronizer and state cycles. The bench therefore reads only after the driven frame and one further idle bit have passed.

Transmitted bits are sampled at bit centres, counted from the negative edge on which the start bit is first seen. Frame spacing is checked as an exact cycle difference between start detections of back-to-back frames. While the transmitter is disabled, the line is compared against high on every clock.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
  typedef enum logic [2:0] {
    REG_TXDATA = 3'd0,
    REG_RXDATA = 3'd1,
    REG_TXCTRL = 3'd2,
    REG_RXCTRL = 3'd3,
    REG_IE     = 3'd4,
    REG_IP     = 3'd5,
    REG_DIV    = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {
    LN_IDLE,
    LN_START,
    LN_DATA,
    LN_STOP
  } line_st_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_LSB = 16;
  localparam int unsigned FLAG_B  = 31;
endpackage

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             do_push, do_pop;

  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (level_o == $past(level_o))); // R2
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o); // R3
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o); // R13
endmodule

// File: rtl/uart_wm_tx.sv
module uart_wm_tx
  import uart_wm_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              two_stop_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              avail_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              pop_o,
  output logic              tx_o
);
  line_st_e          st_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              stop2_q, tx_q;
  logic              bit_end, last_stop, load;

  assign bit_end   = (cnt_q == div_i);
  assign last_stop = (st_q == LN_STOP) && bit_end && (!two_stop_i || stop2_q);
  assign load      = en_i && avail_i && ((st_q == LN_IDLE) || last_stop);
  assign pop_o     = load;
  assign tx_o      = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= LN_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      stop2_q <= 1'b0;
      tx_q    <= 1'b1;
    end else if (load) begin
      st_q  <= LN_START;
      sh_q  <= data_i;
      cnt_q <= '0;
      tx_q  <= 1'b0;
    end else begin
      case (st_q)
        LN_IDLE: begin
          tx_q  <= 1'b1;
          cnt_q <= '0;
        end
        LN_START: begin
          if (bit_end) begin
            st_q  <= LN_DATA;
            cnt_q <= '0;
            bit_q <= '0;
            tx_q  <= sh_q[0];
          end else cnt_q <= cnt_q + 1'b1;
        end
        LN_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (bit_q == 3'd7) begin
              st_q    <= LN_STOP;
              stop2_q <= 1'b0;
              tx_q    <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= sh_q >> 1;
              tx_q  <= sh_q[1];
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (last_stop) st_q <= LN_IDLE;
            else stop2_q <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  AST_TX_OFF_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LN_IDLE && !en_i) |=> tx_o); // R5
  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !tx_o); // R4
  AST_TX_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LN_STOP) |-> tx_o); // R4
endmodule

// File: rtl/uart_wm_rx.sv
module uart_wm_rx
  import uart_wm_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rx_i,
  output logic              push_o,
  output logic [BYTE_W-1:0] data_o
);
  line_st_e          st_q;
  logic [DIV_W-1:0]  cnt_q, half;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              s1_q, s2_q, s3_q, push_q;

  assign half   = div_i >> 1;
  assign push_o = push_q;
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      st_q   <= LN_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      push_q <= 1'b0;
    end else begin
      s1_q   <= rx_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      push_q <= 1'b0;
      case (st_q)
        LN_IDLE: begin
          cnt_q <= '0;
          // falling edge only: a held-low line after a bad stop does not restart
          if (en_i && !s2_q && s3_q) st_q <= LN_START;
        end
        LN_START: begin
          if (cnt_q == half) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= s2_q ? LN_IDLE : LN_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        LN_DATA: begin
          if (cnt_q == div_i) begin
            cnt_q <= '0;
            sh_q  <= {s2_q, sh_q[BYTE_W-1:1]};
            if (bit_q == 3'd7) st_q <= LN_STOP;
            else bit_q <= bit_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == div_i) begin
            cnt_q  <= '0;
            st_q   <= LN_IDLE;
            push_q <= s2_q && en_i;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  AST_RX_STOP_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(s2_q)); // R12
  AST_RX_EN_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(en_i)); // R10
  AST_RX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LN_START && cnt_q == half && s2_q) |=> (st_q == LN_IDLE)); // R11
endmodule

// File: rtl/uart_wm.sv
module uart_wm
  import uart_wm_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_i,
  output logic        tx_o,
  output logic        irq_o
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic             tx_en_q, tx_two_q, rx_en_q;
  logic [LVL_W-1:0] tx_wm_q, rx_wm_q;
  logic [1:0]       ie_q, ip;
  logic [DIV_W-1:0] div_q;
  logic             wr_s, rd_s;
  reg_idx_e         idx;

  logic              txf_push, txf_pop, txf_full, txf_empty;
  logic [BYTE_W-1:0] txf_head;
  logic [LVL_W-1:0]  txf_lvl;
  logic              rxf_push, rxf_pop, rxf_full, rxf_empty;
  logic [BYTE_W-1:0] rxf_in, rxf_head;
  logic [LVL_W-1:0]  rxf_lvl;

  assign idx      = reg_idx_e'(addr_i);
  assign wr_s     = sel_i && wr_i;
  assign rd_s     = sel_i && !wr_i;
  assign txf_push = wr_s && (idx == REG_TXDATA);
  assign rxf_pop  = rd_s && (idx == REG_RXDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q  <= 1'b0;
      tx_two_q <= 1'b0;
      tx_wm_q  <= '0;
      rx_en_q  <= 1'b0;
      rx_wm_q  <= '0;
      ie_q     <= '0;
      div_q    <= DIV_W'(DIV_RST);
    end else if (wr_s) begin
      case (idx)
        REG_TXCTRL: begin
          tx_en_q  <= wdata_i[0];
          tx_two_q <= wdata_i[1];
          tx_wm_q  <= wdata_i[CNT_LSB +: LVL_W];
        end
        REG_RXCTRL: begin
          rx_en_q <= wdata_i[0];
          rx_wm_q <= wdata_i[CNT_LSB +: LVL_W];
        end
        REG_IE:  ie_q  <= wdata_i[1:0];
        REG_DIV: div_q <= wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  assign ip[0] = (txf_lvl < tx_wm_q);
  assign ip[1] = (rxf_lvl > rx_wm_q);
  assign irq_o = |(ip & ie_q);

  always_comb begin
    rdata_o = '0;
    case (idx)
      REG_TXDATA: rdata_o[FLAG_B] = txf_full;
      REG_RXDATA: begin
        rdata_o[FLAG_B] = rxf_empty;
        if (!rxf_empty) rdata_o[BYTE_W-1:0] = rxf_head;
      end
      REG_TXCTRL: begin
        rdata_o[0] = tx_en_q;
        rdata_o[1] = tx_two_q;
        rdata_o[CNT_LSB +: LVL_W] = tx_wm_q;
      end
      REG_RXCTRL: begin
        rdata_o[0] = rx_en_q;
        rdata_o[CNT_LSB +: LVL_W] = rx_wm_q;
      end
      REG_IE:  rdata_o[1:0] = ie_q;
      REG_IP:  rdata_o[1:0] = ip;
      REG_DIV: rdata_o[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  uart_wm_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txf (
    .clk_i, .rst_ni,
    .push_i(txf_push), .data_i(wdata_i[BYTE_W-1:0]), .pop_i(txf_pop),
    .data_o(txf_head), .level_o(txf_lvl), .full_o(txf_full), .empty_o(txf_empty)
  );

  uart_wm_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxf (
    .clk_i, .rst_ni,
    .push_i(rxf_push), .data_i(rxf_in), .pop_i(rxf_pop),
    .data_o(rxf_head), .level_o(rxf_lvl), .full_o(rxf_full), .empty_o(rxf_empty)
  );

  uart_wm_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i, .rst_ni,
    .en_i(tx_en_q), .two_stop_i(tx_two_q), .div_i(div_q),
    .avail_i(!txf_empty), .data_i(txf_head), .pop_o(txf_pop), .tx_o
  );

  uart_wm_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni,
    .en_i(rx_en_q), .div_i(div_q), .rx_i,
    .push_o(rxf_push), .data_o(rxf_in)
  );

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == 2'b00) |-> !irq_o); // R9
  AST_RXWM_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_empty |-> !ip[1]); // R8
  AST_TXWM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txf_full && tx_wm_q <= LVL_W'(DEPTH)) |-> !ip[0]); // R7
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_q |-> !txf_pop); // R5
endmodule

// File: tb/uart_wm_test.sv
module uart_wm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx = 1'b1;
  logic        tx, irq;

  int total = 0, bad = 0, cyc = 0, per = 16;
  bit quiet = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  uart_wm uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx), .tx_o(tx), .irq_o(irq)
  );

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // disabled transmitter: line must stay high on every clock (R5)
  always @(negedge clk) begin
    if (quiet && rst_n) chk("R5 line idle", tx, 1);
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic set_div(input int d);
    reg_wr(3'd6, d);
    per = d + 1;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop_ok);
    @(negedge clk);
    rx = 1'b0;
    repeat (per) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rx = b[k];
      repeat (per) @(negedge clk);
    end
    rx = stop_ok;
    repeat (per) @(negedge clk);
    rx = 1'b1;
    repeat (per + 4) @(negedge clk);
  endtask

  task automatic cap_tx(output logic [7:0] b, output logic stp, output int t0, output bit ok);
    int w;
    w = 0; ok = 1'b0; b = '0; stp = 1'b0; t0 = 0;
    @(negedge clk);
    while (tx !== 1'b0 && w < 400) begin
      @(negedge clk);
      w++;
    end
    if (tx !== 1'b0) return;
    t0 = cyc; ok = 1'b1;
    repeat (per / 2) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      repeat (per) @(negedge clk);
      b[k] = tx;
    end
    repeat (per) @(negedge clk);
    stp = tx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    logic        stp;
    int          t_a, t_b;
    bit          ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset tx high", tx, 1);
    chk("R9 reset irq low", irq, 0);
    reg_rd(3'd6, r);  chk("R1 div reset", r, 15);
    reg_rd(3'd1, r);  chk("R3 rx empty flag", r[31], 1);
    reg_rd(3'd5, r);  chk("R7 ip reset", r, 0);

    set_div(7);
    reg_rd(3'd6, r);  chk("R1 div readback", r, 7);

    // transmit queue fill with transmitter disabled
    quiet = 1'b1;
    reg_wr(3'd2, 32'h0001_0000);
    for (int i = 0; i < 9; i++) reg_wr(3'd0, 32'hFFFF_FFA0 + i);
    reg_rd(3'd0, r);  chk("R2 full flag", r[31], 1);
    reg_rd(3'd5, r);  chk("R7 full not pending", r[0], 0);
    reg_wr(3'd2, 32'h0009_0000);
    reg_rd(3'd5, r);  chk("R7 level 8 below 9", r[0], 1);
    repeat (30) @(negedge clk);
    quiet = 1'b0;

    reg_wr(3'd2, 32'h0001_0001);
    t_a = 0;
    for (int i = 0; i < 8; i++) begin
      cap_tx(b, stp, t_b, ok);
      chk("R4 frame found", ok, 1);
      chk("R2 byte order", b, 8'hA0 + i);
      chk("R4 stop high", stp, 1);
      if (i == 1) chk("R6 one stop spacing", t_b - t_a, 10 * per);
      t_a = t_b;
    end
    cap_tx(b, stp, t_b, ok);
    chk("R2 ninth write dropped", ok, 0);
    reg_rd(3'd5, r);  chk("R7 empty pending", r[0], 1);
    reg_rd(3'd0, r);  chk("R2 not full", r[31], 0);

    // two stop bits
    quiet = 1'b1;
    reg_wr(3'd2, 32'h0001_0002);
    reg_wr(3'd0, 32'h5A);
    reg_wr(3'd0, 32'hC3);
    repeat (10) @(negedge clk);
    quiet = 1'b0;
    reg_wr(3'd2, 32'h0001_0003);
    cap_tx(b, stp, t_a, ok);
    chk("R4 byte 5A", b, 8'h5A);
    cap_tx(b, stp, t_b, ok);
    chk("R4 byte C3", b, 8'hC3);
    chk("R6 two stop spacing", t_b - t_a, 11 * per);
    repeat (3 * per) @(negedge clk);

    reg_wr(3'd4, 32'h1);  chk("R9 tx irq", irq, 1);
    reg_wr(3'd4, 32'h0);  chk("R9 masked", irq, 0);

    // receive path
    reg_wr(3'd3, 32'h0000_0001);
    send_rx(8'h3C, 1'b1);
    reg_rd(3'd5, r);  chk("R8 rx pending", r[1], 1);
    reg_wr(3'd4, 32'h2);  chk("R9 rx irq", irq, 1);
    reg_rd(3'd1, r);  chk("R3 rx byte", r, 32'h3C);
    reg_rd(3'd1, r);  chk("R3 empty after pop", r[31], 1);
    @(negedge clk);   chk("R9 rx irq cleared", irq, 0);
    reg_wr(3'd4, 32'h0);

    reg_wr(3'd3, 32'h0002_0001);
    send_rx(8'h01, 1'b1);
    send_rx(8'hFE, 1'b1);
    reg_rd(3'd5, r);  chk("R8 level 2 not above 2", r[1], 0);
    send_rx(8'h96, 1'b1);
    reg_rd(3'd5, r);  chk("R8 level 3 above 2", r[1], 1);
    reg_rd(3'd1, r);  chk("R3 order 1", r, 32'h01);
    reg_rd(3'd1, r);  chk("R3 order 2", r, 32'hFE);
    reg_rd(3'd1, r);  chk("R3 order 3", r, 32'h96);

    reg_wr(3'd3, 32'h0000_0001);
    send_rx(8'h77, 1'b0);
    reg_rd(3'd1, r);  chk("R12 bad stop dropped", r[31], 1);

    @(negedge clk); rx = 1'b0;
    @(negedge clk); rx = 1'b1;
    repeat (12 * per) @(negedge clk);
    reg_rd(3'd1, r);  chk("R11 1-cycle glitch", r[31], 1);
    @(negedge clk); rx = 1'b0;
    repeat (2) @(negedge clk); rx = 1'b1;
    repeat (12 * per) @(negedge clk);
    reg_rd(3'd1, r);  chk("R11 2-cycle glitch", r[31], 1);

    reg_wr(3'd3, 32'h0);
    send_rx(8'h11, 1'b1);
    reg_rd(3'd1, r);  chk("R10 disabled rx", r[31], 1);

    reg_wr(3'd3, 32'h0000_0001);
    for (int i = 0; i < 9; i++) send_rx(8'h80 + i, 1'b1);
    for (int i = 0; i < 8; i++) begin
      reg_rd(3'd1, r);  chk("R13 kept bytes", r, 32'h80 + i);
    end
    reg_rd(3'd1, r);  chk("R13 overflow dropped", r[31], 1);

    // different divisor
    set_div(3);
    quiet = 1'b1;
    reg_wr(3'd2, 32'h0001_0000);
    reg_wr(3'd0, 32'h69);
    reg_wr(3'd0, 32'hE1);
    repeat (4) @(negedge clk);
    quiet = 1'b0;
    reg_wr(3'd2, 32'h0001_0001);
    cap_tx(b, stp, t_a, ok);
    chk("R1 div3 byte 69", b, 8'h69);
    cap_tx(b, stp, t_b, ok);
    chk("R1 div3 byte E1", b, 8'hE1);
    chk("R1 div3 spacing", t_b - t_a, 40);
    send_rx(8'hA5, 1'b1);
    reg_rd(3'd1, r);  chk("R1 div3 rx byte", r, 32'hA5);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule